// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block controls 85 general-purpose pins, grouped in banks of 32, through a synchronous register port. Software sets and clears output bits atomically, chooses the drive direction of each pin, and watches each pin's level after a two-stage synchronizer. It can arm detection of rising edges, falling edges or both on any pin. A detected edge latches into a status register and raises a single interrupt line. Software clears a status bit by writing a 1 to it.

Each pin also carries a 2-bit mode field. Mode zero keeps the pin under GPIO control. Any other mode hands the pin's output value and output enable to an attached peripheral through the alternate-function inputs. The mode fields are exported so that peripherals can tell which pins they own.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_oe` is all zero, `pin_out` is all zero and `irq` is 0.
- R2: The LEVEL register (function 0) returns each pin's state after a two-flop synchronizer. Bits for pins at or above 85 read 0, so bank 2 shows only bits 20:0.
- R3: Writing to SET (function 1) forces to 1 the output bits whose write-data bit is 1 and leaves the rest unchanged. SET always reads 0.
- R4: Writing to CLEAR (function 2) forces to 0 the output bits whose write-data bit is 1 and leaves the rest unchanged. CLEAR always reads 0.
- R5: DIR (function 3) is read/write. In GPIO mode a 1 drives the pin (`pin_oe`=1) and a 0 makes it an input.
- R6: When a pin's bit in RISE (function 4) is 1, a 0-to-1 change of its synchronized level sets its bit in EDGE (function 6). With the enable at 0, that change sets nothing.
- R7: When a pin's bit in FALL (function 5) is 1, a 1-to-0 change sets its EDGE bit. RISE and FALL can both be set on one pin.
- R8: Writing 1 to an EDGE bit clears it, and writing 0 has no effect. If an enabled edge arrives in the same cycle as the clear, the bit stays set.
- R9: `irq` is 1 exactly when at least one EDGE bit is set.
- R10: AFLO (function 7) holds the 2-bit modes of bank pins 0..15, and AFHI (function 8) holds those of pins 16..31. Pin k's mode sits at bits 2k+1:2k of its register. A non-zero mode routes `alt_out`/`alt_oe` to `pin_out`/`pin_oe` for that pin. Mode 0 routes the GPIO registers.
- R11: The register address is {function[3:0], bank[1:0]}, so the address equals function*4 + bank. Read data appears on `reg_rdata` one clock after `reg_rd`. Reads of bank 3 or of undefined functions return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | {function, bank} register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| pin_in | input | 85 | Pin input levels (asynchronous) |
| pin_out | output | 85 | Pin output values |
| pin_oe | output | 85 | Pin output enables |
| alt_out | input | 85 | Peripheral output values |
| alt_oe | input | 85 | Peripheral output enables |
| alt_in | output | 85 | Synchronized pin levels for peripherals |
| alt_sel | output | 170 | Per-pin 2-bit mode fields |
| irq | output | 1 | OR of all edge status bits |

## Verification
The assertions assume that `reg_wr` and `reg_rd` never carry X after reset. They also assume that at most one register is written per cycle, because the single address port allows nothing else. The stimulus drives every input at the falling clock edge and holds each pin level for several cycles. This gives the synchronizer and the edge detector a clean, single transition to see. The one exception is the same-cycle clear case. There the pin change is timed so that the detected edge and the clear write reach the status register at the same rising edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int FN_W = 4;

   typedef enum logic [FN_W-1:0] {
      FN_LEVEL = 4'd0,
      FN_SET   = 4'd1,
      FN_CLR   = 4'd2,
      FN_DIR   = 4'd3,
      FN_RISE  = 4'd4,
      FN_FALL  = 4'd5,
      FN_EDGE  = 4'd6,
      FN_AFLO  = 4'd7,
      FN_AFHI  = 4'd8
   } gpio_fn_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 85,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit #(
   parameter int W = 85
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] rise_en,
   input  logic [W-1:0] fall_en,
   input  logic [W-1:0] clr_mask,
   output logic [W-1:0] status,
   output logic         irq
);
   logic [W-1:0] prev_q;
   logic [W-1:0] event_v;

   assign event_v = (lvl & ~prev_q & rise_en) | (~lvl & prev_q & fall_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         status <= '0;
      end else begin
         prev_q <= lvl;
         status <= (status & ~clr_mask) | event_v;
      end
   end

   assign irq = |status;

   // R6 R7 R8: a detected edge always lands in status, even against a clear
   assert_edge_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|event_v) |=> ((status & $past(event_v)) == $past(event_v)));

   // R8: a clear with no competing edge empties the bit
   assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_mask & ~event_v)) |=> ((status & $past(clr_mask & ~event_v)) == '0));

   // R6 R7: status only rises where an enabled edge was seen
   assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status & ~$past(status) & ~$past(event_v)) == '0));
endmodule

// File: rtl/gpio_af_mux.sv
module gpio_af_mux #(
   parameter int W    = 85,
   parameter int AF_W = 2
) (
   input  logic [W-1:0]      gpio_val,
   input  logic [W-1:0]      gpio_dir,
   input  logic [W-1:0]      alt_val,
   input  logic [W-1:0]      alt_en,
   input  logic [W*AF_W-1:0] mode,
   output logic [W-1:0]      pin_val,
   output logic [W-1:0]      pin_en
);
   for (genvar i = 0; i < W; i++) begin : g_pin
      logic alt_owned;
      assign alt_owned = |mode[i*AF_W +: AF_W];
      assign pin_val[i] = alt_owned ? alt_val[i] : gpio_val[i];
      assign pin_en[i]  = alt_owned ? alt_en[i]  : gpio_dir[i];
   end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_pkg::*;
#(
   parameter int NUM_PINS   = 85,
   parameter int BANK_W     = 32,
   parameter int AF_W       = 2,
   parameter int SYNC_DEPTH = 2,
   localparam int NUM_BANKS  = (NUM_PINS + BANK_W - 1) / BANK_W,
   localparam int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int ADDR_W     = FN_W + BANK_IDX_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_wr,
   input  logic                     reg_rd,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic [BANK_W-1:0]        reg_wdata,
   output logic [BANK_W-1:0]        reg_rdata,
   input  logic [NUM_PINS-1:0]      pin_in,
   output logic [NUM_PINS-1:0]      pin_out,
   output logic [NUM_PINS-1:0]      pin_oe,
   input  logic [NUM_PINS-1:0]      alt_out,
   input  logic [NUM_PINS-1:0]      alt_oe,
   output logic [NUM_PINS-1:0]      alt_in,
   output logic [NUM_PINS*AF_W-1:0] alt_sel,
   output logic                     irq
);
   localparam int PAD_W      = NUM_BANKS * BANK_W;
   localparam int AF_PER_REG = BANK_W / AF_W;
   localparam int AF_REGS    = BANK_W / AF_PER_REG;

   if (AF_W != 2) begin : g_bad_af
      $error("gpio_bank_ctrl: AF_W must be 2 (two select registers per bank)");
   end
   if (AF_REGS != 2) begin : g_bad_split
      $error("gpio_bank_ctrl: mode fields must split over exactly two registers");
   end
   if (NUM_PINS < 1) begin : g_bad_pins
      $error("gpio_bank_ctrl: NUM_PINS must be positive");
   end

   // ---------------- address decode ----------------
   gpio_fn_e              acc_fn;
   logic [BANK_IDX_W-1:0] acc_bank;
   logic                  bank_ok;

   assign acc_fn   = gpio_fn_e'(reg_addr[ADDR_W-1 -: FN_W]);
   assign acc_bank = reg_addr[BANK_IDX_W-1:0];
   assign bank_ok  = int'(acc_bank) < NUM_BANKS;

   function automatic logic wr_hit(input gpio_fn_e f);
      return reg_wr && bank_ok && (acc_fn == f);
   endfunction

   // ---------------- per-pin write masks ----------------
   logic [NUM_PINS-1:0]      wdata_bit;
   logic [NUM_PINS-1:0]      bank_sel;
   logic [NUM_PINS-1:0]      set_m, clr_m, edge_clr_m;
   logic [NUM_PINS-1:0]      dir_we, rise_we, fall_we, af_we;
   logic [NUM_PINS*AF_W-1:0] af_wdata;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_wmask
      localparam int B  = i / BANK_W;
      localparam int J  = i % BANK_W;
      localparam int K  = J % AF_PER_REG;
      localparam bit HI = (J >= AF_PER_REG);
      assign bank_sel[i]   = (int'(acc_bank) == B);
      assign wdata_bit[i]  = reg_wdata[J];
      assign set_m[i]      = wr_hit(FN_SET)  && bank_sel[i] && reg_wdata[J];
      assign clr_m[i]      = wr_hit(FN_CLR)  && bank_sel[i] && reg_wdata[J];
      assign edge_clr_m[i] = wr_hit(FN_EDGE) && bank_sel[i] && reg_wdata[J];
      assign dir_we[i]     = wr_hit(FN_DIR)  && bank_sel[i];
      assign rise_we[i]    = wr_hit(FN_RISE) && bank_sel[i];
      assign fall_we[i]    = wr_hit(FN_FALL) && bank_sel[i];
      assign af_we[i]      = wr_hit(HI ? FN_AFHI : FN_AFLO) && bank_sel[i];
      assign af_wdata[i*AF_W +: AF_W] = reg_wdata[K*AF_W +: AF_W];
   end

   // ---------------- control state ----------------
   logic [NUM_PINS-1:0]      out_q, dir_q, rise_q, fall_q;
   logic [NUM_PINS*AF_W-1:0] af_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         dir_q  <= '0;
         rise_q <= '0;
         fall_q <= '0;
      end else begin
         out_q  <= (out_q | set_m) & ~clr_m;
         dir_q  <= (dir_q  & ~dir_we)  | (wdata_bit & dir_we);
         rise_q <= (rise_q & ~rise_we) | (wdata_bit & rise_we);
         fall_q <= (fall_q & ~fall_we) | (wdata_bit & fall_we);
      end
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_af_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        af_q[i*AF_W +: AF_W] <= '0;
         else if (af_we[i]) af_q[i*AF_W +: AF_W] <= af_wdata[i*AF_W +: AF_W];
      end
   end

   // ---------------- input path ----------------
   logic [NUM_PINS-1:0] lvl_s;
   logic [NUM_PINS-1:0] edge_q;

   gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_DEPTH)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (lvl_s)
   );

   gpio_edge_unit #(.W(NUM_PINS)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl_s),
      .rise_en  (rise_q),
      .fall_en  (fall_q),
      .clr_mask (edge_clr_m),
      .status   (edge_q),
      .irq      (irq)
   );

   // ---------------- output path ----------------
   gpio_af_mux #(.W(NUM_PINS), .AF_W(AF_W)) u_mux (
      .gpio_val (out_q),
      .gpio_dir (dir_q),
      .alt_val  (alt_out),
      .alt_en   (alt_oe),
      .mode     (af_q),
      .pin_val  (pin_out),
      .pin_en   (pin_oe)
   );

   assign alt_in  = lvl_s;
   assign alt_sel = af_q;

   // ---------------- read path ----------------
   logic [PAD_W-1:0]      lvl_p, dir_p, rise_p, fall_p, edge_p;
   logic [PAD_W*AF_W-1:0] af_p;

   for (genvar p = 0; p < PAD_W; p++) begin : g_pad
      if (p < NUM_PINS) begin : g_real
         assign lvl_p[p]  = lvl_s[p];
         assign dir_p[p]  = dir_q[p];
         assign rise_p[p] = rise_q[p];
         assign fall_p[p] = fall_q[p];
         assign edge_p[p] = edge_q[p];
         assign af_p[p*AF_W +: AF_W] = af_q[p*AF_W +: AF_W];
      end else begin : g_empty
         assign lvl_p[p]  = 1'b0;
         assign dir_p[p]  = 1'b0;
         assign rise_p[p] = 1'b0;
         assign fall_p[p] = 1'b0;
         assign edge_p[p] = 1'b0;
         assign af_p[p*AF_W +: AF_W] = '0;
      end
   end

   logic [BANK_W-1:0] rd_word;
   int unsigned       rd_base;

   always_comb begin
      rd_base = bank_ok ? int'(acc_bank) : 0;
      rd_word = '0;
      if (bank_ok) begin
         unique case (acc_fn)
            FN_LEVEL: rd_word = lvl_p[rd_base*BANK_W +: BANK_W];
            FN_DIR:   rd_word = dir_p[rd_base*BANK_W +: BANK_W];
            FN_RISE:  rd_word = rise_p[rd_base*BANK_W +: BANK_W];
            FN_FALL:  rd_word = fall_p[rd_base*BANK_W +: BANK_W];
            FN_EDGE:  rd_word = edge_p[rd_base*BANK_W +: BANK_W];
            FN_AFLO:  rd_word = af_p[rd_base*BANK_W*AF_W +: BANK_W];
            FN_AFHI:  rd_word = af_p[rd_base*BANK_W*AF_W + BANK_W +: BANK_W];
            default:  rd_word = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_word;
   end

   // ---------------- assertions ----------------
   assert_set_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_m) |=> ((out_q & $past(set_m)) == $past(set_m)));

   assert_clr_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_m) |=> ((out_q & $past(clr_m)) == '0));

   assert_untouched_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> $stable(out_q));

   assert_strobe_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && (acc_fn == FN_SET || acc_fn == FN_CLR)) |=> (reg_rdata == '0));

   assert_irq_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(reg_wr && acc_fn == FN_EDGE)) |=> irq);
endmodule

// File: tb/gpio_bank_ctrl_tb_top.sv
module gpio_bank_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 85;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic          reg_rd = 1'b0;
   logic [5:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe, alt_in;
   logic [NP-1:0] alt_out = '0;
   logic [NP-1:0] alt_oe = '0;
   logic [2*NP-1:0] alt_sel;
   logic          irq;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } rd_item_t;
   rd_item_t exp_q[$];
   logic     rd_seen = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_bank_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in),
      .alt_sel(alt_sel), .irq(irq)
   );

   function automatic logic [5:0] ad(input int fn, input int bank);
      return 6'(fn * 4 + bank);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard when read data is valid
   always @(posedge clk) rd_seen <= reg_rd;
   always @(negedge clk) begin
      if (rd_seen && exp_q.size() > 0) begin
         rd_item_t it;
         it = exp_q.pop_front();
         check(it.tag, reg_rdata, it.exp);
      end
   end

   task automatic wr(input int fn, input int bank, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = ad(fn, bank); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int fn, input int bank, input logic [31:0] exp, input string tag);
      rd_item_t it;
      it.exp = exp; it.tag = tag;
      exp_q.push_back(it);
      reg_rd = 1'b1; reg_addr = ad(fn, bank);
      @(negedge clk);
      reg_rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (10000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3, 0, 32'h0, "R1 dir reset");
      rd(6, 1, 32'h0, "R1 edge reset");
      check("R1 irq", 32'(irq), 32'h0);
      check("R1 pin_oe", pin_oe[31:0], 32'h0);
      check("R1 pin_out", pin_out[31:0], 32'h0);

      // R5 direction
      wr(3, 0, 32'h0000_00FF);
      rd(3, 0, 32'h0000_00FF, "R5 dir readback");
      check("R5 pin_oe", pin_oe[31:0], 32'h0000_00FF);

      // R3 set
      wr(1, 0, 32'h0000_000F);
      check("R3 set", pin_out[31:0], 32'h0000_000F);
      wr(1, 0, 32'h0);
      check("R3 zero write ignored", pin_out[31:0], 32'h0000_000F);
      rd(1, 0, 32'h0, "R3 set reads zero");

      // R4 clear
      wr(2, 0, 32'h0000_0003);
      check("R4 clear", pin_out[31:0], 32'h0000_000C);
      rd(2, 0, 32'h0, "R4 clr reads zero");

      // R2 level, R11 unmapped
      pin_in = '1;
      settle();
      rd(0, 2, 32'h001F_FFFF, "R2 level bank2");
      rd(0, 0, 32'hFFFF_FFFF, "R2 level bank0");
      rd(0, 3, 32'h0, "R11 bank3 zero");
      rd(12, 0, 32'h0, "R11 undefined fn zero");
      rd(6, 1, 32'h0, "R6 no enable no status");

      // R6 rise, R7 fall
      wr(4, 1, 32'h0000_0001);
      wr(5, 1, 32'h0000_0006);
      pin_in[32] = 1'b0;
      settle();
      rd(6, 1, 32'h0, "R6 falling ignored without fall enable");
      pin_in[32] = 1'b1;
      settle();
      pin_in[33] = 1'b0;
      settle();
      rd(6, 1, 32'h0000_0003, "R7 rise and fall captured");
      check("R9 irq set", 32'(irq), 32'h1);

      // R8 write-one-to-clear
      wr(6, 1, 32'h0);
      rd(6, 1, 32'h0000_0003, "R8 zero write no effect");
      wr(6, 1, 32'h0000_0001);
      rd(6, 1, 32'h0000_0002, "R8 clear one bit");
      wr(6, 1, 32'h0000_0002);
      rd(6, 1, 32'h0, "R8 clear all");
      check("R9 irq clear", 32'(irq), 32'h0);

      // R7 both edges on pin 34, R8 same-cycle edge vs clear
      wr(4, 1, 32'h0000_0005);
      pin_in[34] = 1'b0;
      settle();
      rd(6, 1, 32'h0000_0004, "R7 both enabled fall");
      pin_in[34] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr(6, 1, 32'h0000_0004);
      settle();
      rd(6, 1, 32'h0000_0004, "R8 edge beats clear");
      wr(6, 1, 32'h0000_0004);
      rd(6, 1, 32'h0, "R8 later clear");

      // R10 alternate functions
      alt_out = '1;
      alt_oe  = '1;
      wr(7, 0, 32'h0000_0004);
      wr(8, 0, 32'h0000_000C);
      rd(7, 0, 32'h0000_0004, "R10 aflo readback");
      rd(8, 0, 32'h0000_000C, "R10 afhi readback");
      check("R10 alt drives pin1", 32'(pin_out[1]), 32'h1);
      check("R10 alt oe pin17", 32'(pin_oe[17]), 32'h1);
      check("R10 gpio keeps pin0", 32'(pin_out[0]), 32'h0);
      check("R10 gpio oe pin16", 32'(pin_oe[16]), 32'h0);
      check("R10 alt_sel pin1", 32'(alt_sel[3:2]), 32'h1);

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R11 pending reads actual=%0d expected=0", exp_q.size());
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule